// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block is the receive-side buffer of a PC-compatible serial port. Bytes that a separate deserializer has already assembled arrive on a valid strobe; a break-detect strobe stands for a received line break. With queueing enabled, bytes go into a 16-entry first-in first-out store. With queueing disabled, a single holding byte is used instead. A host read strobe takes the oldest byte. A status-read strobe clears the sticky error flags.

A FIFO control write selects the mode and the trigger depth. It can also flush the store. A flag tells the host that the programmed depth has been reached. A second flag rises when bytes have sat unread for four character times. One character time is a frame length in bit ticks, and the block works it out from the line-control bits. The same control write also produces a one-cycle flush pulse for the transmit side.

Top module: `uart_rx_queue`

## Requirements
- R1: A control write stores only bits 7, 6, 3 and 0 of the written value (value AND 0xC9), visible on `fifo_ctl` the cycle after the write. Bit 0 enables queue mode and bits 7:6 select the trigger depth.
- R2: A control write whose bit 0 differs from the stored bit 0 empties the receive store and clears data-ready, break and timeout. The same write, or any write with bit 2 set, raises `xmit_flush` for exactly the one cycle after the write.
- R3: A control write with bit 1 set empties the receive store and clears data-ready, break and timeout. It leaves the overrun flag unchanged.
- R4: In queue mode, a byte or break that arrives while 16 bytes are held is dropped and the held bytes stay unchanged. The overrun flag is set, and it stays set until a `stat_rd` strobe.
- R5: In queue mode, `tmo_pend` rises exactly 4 × F bit ticks after the last receive or read edge, if data is still held, where F is the frame length of R10. A host read clears it and restarts the count if data remains. A read that empties the store stops the count.
- R6: In queue mode, `rd_data` shows the oldest held byte, or 0x00 when the store is empty. A read edge removes that byte. `data_ready` is 1 exactly while the store holds data.
- R7: A break pushes a 0x00 byte and sets both break and data-ready. Break clears on `stat_rd`, or when a read empties the store.
- R8: In queue mode, `trig_hit` is 1 while the held count is at least 1, 4, 8 or 14, for bits 7:6 of 00, 01, 10 or 11. In single mode, `trig_hit` equals `data_ready`.
- R9: In single mode, a byte that arrives while data-ready is set replaces the held byte and sets overrun. A read clears data-ready.
- R10: Frame length in bit ticks is 1 start + (line_ctl[1:0] + 5) data + line_ctl[3] parity + (1 + line_ctl[2]) stop bits.
- R11: After reset the block is in single mode with `fifo_ctl` = 0x00, all flags at 0 and `rd_data` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| brk_det | input | 1 | Line break received (takes priority over rx_valid) |
| rd_en | input | 1 | Host reads the receive data |
| stat_rd | input | 1 | Host reads status; clears overrun and break |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| line_ctl | input | 4 | Word length [1:0], stop select [2], parity enable [3] |
| bit_tick | input | 1 | One pulse per serial bit time |
| rd_data | output | 8 | Byte the next read returns |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | Sticky overrun flag |
| brk_flag | output | 1 | Break received flag |
| trig_hit | output | 1 | Trigger depth reached |
| tmo_pend | output | 1 | Character timeout pending |
| fifo_ctl | output | 8 | Stored FIFO control value |
| xmit_flush | output | 1 | One-cycle transmit-store flush pulse |

## Verification
A wrong fill count shows on `trig_hit` on the very next cycle of a trigger sweep, and on `data_ready` and `rd_data` when the store is drained. A stale or advanced read pointer shows as a wrong byte on the first read that follows. A timer that is off by one bit tick, or that fails to restart, moves the rise of `tmo_pend` away from the exact 4 × F cycle boundary. The bench samples on both sides of that boundary for all sixteen frame formats. A lost overrun or break flag is seen at the next status sample, before any `stat_rd` strobe.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // frame length in bit ticks: start + data + parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] lc);
    return 4'd7 + {2'b00, lc[1:0]} + {3'b000, lc[2]} + {3'b000, lc[3]};
  endfunction

  // trigger depth from the two select bits
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; fill_q <= '0;
    end else if (clr) begin
      wp_q <= '0; rp_q <= '0; fill_q <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      fill_q <= fill_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp_q] <= din;
  end

  assign head  = mem[rp_q];
  assign fill  = fill_q;
  assign full  = (fill_q == CW'(DEPTH));
  assign empty = (fill_q == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int TICKS = 4,
  parameter int FW    = 4,
  localparam int TW   = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic [FW-1:0] frame_len,
  input  logic          restart,
  input  logic          halt,
  output logic          expire
);
  logic          run_q;
  logic [TW-1:0] cnt_q;
  logic [FW-1:0] bcnt_q;
  logic          char_tick;

  assign char_tick = run_q && bit_tick && (bcnt_q == frame_len - 1'b1);
  assign expire    = char_tick && (cnt_q == TW'(TICKS - 1)) && !restart && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; cnt_q <= '0; bcnt_q <= '0;
    end else if (halt) begin
      run_q <= 1'b0; cnt_q <= '0; bcnt_q <= '0;
    end else if (restart) begin
      run_q <= 1'b1; cnt_q <= '0; bcnt_q <= '0;
    end else if (run_q && bit_tick) begin
      if (char_tick) begin
        bcnt_q <= '0;
        if (cnt_q != TW'(TICKS)) cnt_q <= cnt_q + 1'b1;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assert_count_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(TICKS));
  assert_expire_then_saturated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == TW'(TICKS)));
  assert_bitcount_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (bcnt_q < frame_len));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TICKS = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       brk_det,
  input  logic       rd_en,
  input  logic       stat_rd,
  input  logic       fcr_we,
  input  logic [7:0] fcr_wdata,
  input  logic [3:0] line_ctl,
  input  logic       bit_tick,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       overrun,
  output logic       brk_flag,
  output logic       trig_hit,
  output logic       tmo_pend,
  output logic [7:0] fifo_ctl,
  output logic       xmit_flush
);
  logic [7:0] fcr_q, hold_q, head;
  logic       dr_q, brk_q, ovr_q, tmo_q, xfl_q;
  logic [CW-1:0] fill, fill_next;
  logic       full, empty;

  // named internal events
  logic fifo_mode, en_flip, rx_clr, byte_ev, push, pop;
  logic ovf_fifo, ovf_hold, drained, restart, halt, expire;
  logic [7:0] byte_in;

  assign fifo_mode = fcr_q[0];
  assign en_flip   = fcr_we && (fcr_wdata[0] != fcr_q[0]);
  assign rx_clr    = (fcr_we && fcr_wdata[1]) || en_flip;
  assign byte_ev   = rx_valid || brk_det;
  assign byte_in   = brk_det ? 8'h00 : rx_byte;
  assign push      = fifo_mode && byte_ev && !full && !rx_clr;
  assign ovf_fifo  = fifo_mode && byte_ev && full && !rx_clr;
  assign ovf_hold  = !fifo_mode && byte_ev && dr_q && !rx_clr;
  assign pop       = fifo_mode && rd_en && !empty && !rx_clr;
  assign fill_next = fill + CW'(push) - CW'(pop);
  assign drained   = fifo_mode && rd_en && !rx_clr && (fill_next == '0);
  assign restart   = fifo_mode && !rx_clr && (byte_ev || rd_en) && (fill_next != '0);
  assign halt      = rx_clr || drained;

  rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(push), .pop(pop),
    .din(byte_in), .head(head), .fill(fill), .full(full), .empty(empty)
  );

  rxq_timer #(.TICKS(TICKS), .FW(4)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .frame_len(frame_bits(line_ctl)), .restart(restart), .halt(halt),
    .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q <= '0; hold_q <= '0; dr_q <= 1'b0; brk_q <= 1'b0;
      ovr_q <= 1'b0; tmo_q <= 1'b0; xfl_q <= 1'b0;
    end else begin
      if (fcr_we) fcr_q <= fcr_wdata & 8'hC9;
      xfl_q <= fcr_we && (fcr_wdata[2] || en_flip);

      if (!fifo_mode && byte_ev && !rx_clr) hold_q <= byte_in;

      if (rx_clr)                            dr_q <= 1'b0;
      else if (byte_ev)                      dr_q <= 1'b1;
      else if (drained || (!fifo_mode && rd_en)) dr_q <= 1'b0;

      if (rx_clr)                            brk_q <= 1'b0;
      else if (brk_det)                      brk_q <= 1'b1;
      else if (stat_rd)                      brk_q <= 1'b0;
      else if (drained || (!fifo_mode && rd_en)) brk_q <= 1'b0;

      if (ovf_fifo || ovf_hold)              ovr_q <= 1'b1;
      else if (stat_rd)                      ovr_q <= 1'b0;

      if (halt || (fifo_mode && rd_en))      tmo_q <= 1'b0;
      else if (expire)                       tmo_q <= 1'b1;
    end
  end

  assign rd_data    = fifo_mode ? (empty ? 8'h00 : head) : hold_q;
  assign data_ready = dr_q;
  assign overrun    = ovr_q;
  assign brk_flag   = brk_q;
  assign trig_hit   = fifo_mode ? (fill >= CW'(trig_level(fcr_q[7:6]))) : dr_q;
  assign tmo_pend   = tmo_q;
  assign fifo_ctl   = fcr_q;
  assign xmit_flush = xfl_q;

  assert_ready_tracks_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |-> (dr_q == !empty));
  assert_overrun_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_fifo && !pop) |=> ($stable(fill) && overrun));
  assert_flip_flushes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_flip |=> (empty && !data_ready && !tmo_pend && xmit_flush));
  assert_rxreset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (empty && !data_ready && !brk_flag));
  assert_break_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && fifo_mode && !full && !rx_clr) |=> (data_ready && brk_flag));
  assert_timeout_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> !empty);
  assert_hold_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hold |=> overrun);
endmodule

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, brk_det = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
  logic       fcr_we = 1'b0, bit_tick = 1'b1;
  logic [7:0] rx_byte = '0, fcr_wdata = '0;
  logic [3:0] line_ctl = '0;
  logic [7:0] rd_data, fifo_ctl;
  logic       data_ready, overrun, brk_flag, trig_hit, tmo_pend, xmit_flush;
  int         n_chk = 0, n_err = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  uart_rx_queue uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .brk_det(brk_det), .rd_en(rd_en), .stat_rd(stat_rd), .fcr_we(fcr_we),
    .fcr_wdata(fcr_wdata), .line_ctl(line_ctl), .bit_tick(bit_tick),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
    .brk_flag(brk_flag), .trig_hit(trig_hit), .tmo_pend(tmo_pend),
    .fifo_ctl(fifo_ctl), .xmit_flush(xmit_flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick1(); @(negedge clk); endtask
  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic put_brk();
    brk_det = 1'b1; @(negedge clk); brk_det = 1'b0;
  endtask
  task automatic take(output logic [7:0] b);
    b = rd_data; rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic wfcr(input logic [7:0] v);
    fcr_we = 1'b1; fcr_wdata = v; @(negedge clk); fcr_we = 1'b0;
  endtask
  task automatic sread();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  function automatic int frame_of(input logic [3:0] l);
    return 1 + (5 + int'(l[1:0])) + int'(l[3]) + (l[2] ? 2 : 1);
  endfunction
  function automatic int level_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction
  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 37 + k * 11 + 1) & 255);
  endfunction

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick1();
    // R11 reset state
    chk("R11 fifo_ctl", fifo_ctl, 8'h00);
    chk("R11 data_ready", data_ready, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 brk_flag", brk_flag, 0);
    chk("R11 tmo_pend", tmo_pend, 0);
    chk("R11 trig_hit", trig_hit, 0);
    chk("R11 rd_data", rd_data, 8'h00);

    // R1 mask, R2 flush pulse on enable change
    wfcr(8'hFF);
    chk("R1 stored mask", fifo_ctl, 8'hC9);
    chk("R2 xmit_flush pulse", xmit_flush, 1);
    tick1();
    chk("R2 xmit_flush one cycle", xmit_flush, 0);

    // R8 trigger sweep, R4 overrun, R6 ordered drain
    for (int s = 0; s < 4; s++) begin
      wfcr(8'((s << 6) | 8'h03));
      for (int k = 1; k <= 16; k++) begin
        put(pat(s, k));
        chk($sformatf("R8 trig sel=%0d cnt=%0d", s, k), trig_hit, (k >= level_of(s)) ? 1 : 0);
      end
      put(8'hEE);
      chk("R4 overrun set", overrun, 1);
      chk("R6 ready when full", data_ready, 1);
      for (int k = 1; k <= 16; k++) begin
        take(got);
        chk($sformatf("R4 R6 byte kept sel=%0d idx=%0d", s, k), got, pat(s, k));
        chk("R6 ready vs fill", data_ready, (k < 16) ? 1 : 0);
      end
      chk("R6 empty reads zero", rd_data, 8'h00);
      chk("R4 overrun sticky", overrun, 1);
      sread();
      chk("R4 status read clears overrun", overrun, 0);
    end

    // R5 timeout boundary for every frame format (R10 frame length)
    for (int l = 0; l < 16; l++) begin
      line_ctl = 4'(l);
      wfcr(8'h03);
      put(8'h40 + 8'(l));
      repeat (4 * frame_of(4'(l)) - 1) tick1();
      chk($sformatf("R5 R10 no timeout yet lc=%0d", l), tmo_pend, 0);
      tick1();
      chk($sformatf("R5 R10 timeout at 4F lc=%0d", l), tmo_pend, 1);
      take(got);
      chk("R5 read clears timeout", tmo_pend, 0);
      repeat (5 * frame_of(4'(l))) tick1();
      chk("R5 no timeout when empty", tmo_pend, 0);
    end

    // R5 a read restarts the count
    line_ctl = 4'd0;
    wfcr(8'h03);
    put(8'h01);
    put(8'h02);
    repeat (2 * 7) tick1();
    take(got);
    chk("R5 restart read value", got, 8'h01);
    repeat (4 * 7 - 1) tick1();
    chk("R5 restarted not yet", tmo_pend, 0);
    tick1();
    chk("R5 restarted fires", tmo_pend, 1);
    take(got);
    chk("R5 read clears after restart", tmo_pend, 0);

    // R7 break in queue mode
    wfcr(8'h03);
    put_brk();
    chk("R7 break data_ready", data_ready, 1);
    chk("R7 break flag", brk_flag, 1);
    chk("R7 break byte zero", rd_data, 8'h00);
    put(8'h5A);
    take(got);
    chk("R7 break byte popped", got, 8'h00);
    chk("R7 break held while data", brk_flag, 1);
    take(got);
    chk("R7 next byte", got, 8'h5A);
    chk("R7 break clears on empty", brk_flag, 0);
    put_brk();
    sread();
    chk("R7 status read clears break", brk_flag, 0);
    chk("R7 data still ready", data_ready, 1);

    // R2 bit 2 alone: flush pulse, receive data kept
    wfcr(8'h05);
    chk("R2 bit2 pulse", xmit_flush, 1);
    chk("R2 bit2 keeps data", data_ready, 1);

    // R3 receive reset keeps overrun
    wfcr(8'h03);
    for (int k = 0; k < 17; k++) put(8'(k));
    chk("R3 pre overrun", overrun, 1);
    wfcr(8'h03);
    chk("R3 empties", data_ready, 0);
    chk("R3 read zero", rd_data, 8'h00);
    chk("R3 overrun unchanged", overrun, 1);
    sread();

    // R2 enable change with data present
    put(8'h33);
    put_brk();
    wfcr(8'h00);
    chk("R2 flip clears ready", data_ready, 0);
    chk("R2 flip clears break", brk_flag, 0);
    chk("R2 flip pulse", xmit_flush, 1);
    chk("R1 single mode stored", fifo_ctl, 8'h00);

    // R9 single holding register
    put(8'h11);
    chk("R9 ready", data_ready, 1);
    chk("R9 value", rd_data, 8'h11);
    chk("R8 single trig equals ready", trig_hit, 1);
    chk("R9 no overrun yet", overrun, 0);
    put(8'h22);
    chk("R9 overrun", overrun, 1);
    chk("R9 replaced", rd_data, 8'h22);
    take(got);
    chk("R9 read value", got, 8'h22);
    chk("R9 read clears ready", data_ready, 0);
    chk("R8 single trig low", trig_hit, 0);
    sread();

    // R2 back to queue mode flushes the holding byte's ready
    put(8'h77);
    wfcr(8'h01);
    chk("R2 enable clears ready", data_ready, 0);
    chk("R6 empty queue zero", rd_data, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule